// File: doc/BRIEF.md
# Snoop Resolution Unit

This unit decides how a top-level coherent cache answers one snoop from the bus. For the snooped block it receives four inputs in the same cycle: the snoop itself (command, address, byte count), the state of the matching miss entry, the contents of the writeback buffer, and a supply decision from the coherence policy. It then picks exactly one course of action. A miss entry that is already in service has the highest priority. It either refuses the snoop with a NACK or has an invalidate appended to it. Next comes a cacheable writeback entry for the same block. That entry can supply the requested bytes, be marked in service, or both. When neither case applies, the snoop goes to the coherence policy, which also updates the tag state.

Side-effect requests (append an invalidate, mark a writeback entry, consult the policy) are single-cycle pulses in the cycle the snoop is accepted. A response carries the satisfied, NACK and shared flags, the requested bytes and an overrun flag. It appears a fixed number of cycles after acceptance. While a response is pending, the unit shows busy and accepts no new snoop.

Top module: `snoop_resolver`

## Requirements
- R1: A snoop is accepted in a cycle where `snp_valid_i` is 1 and `busy_o` is 0. A snoop offered while `busy_o` is 1 raises no pulse and leaves the pending response unchanged.
- R2: If the miss entry matches and is in service, and its pending request is an invalidate type (`miss_inval_i`=1) or is not a cache fill (`miss_fill_i`=0), and the snoop is a read or a read-exclusive (command 0 or 1), the unit answers with satisfied=1, NACK=1, shared=0 and zero data. It raises no other pulse.
- R3: In every other case where the miss entry matches and is in service, `miss_append_inv_o` pulses in the accept cycle. No response follows, and neither `wb_mark_o` nor `coh_req_o` is raised.
- R4: If no in-service miss entry matches, the unit selects the lowest-index writeback entry that is valid, not uncacheable, and whose address bits above the block offset equal those of the snoop. Uncacheable entries are skipped. A miss entry that matches but is not in service does not block this step.
- R5: A read or read-exclusive snoop (command 0 or 1) that selects a writeback entry gets a response with satisfied=1, shared=1 and NACK=0. Output byte i (bits 8i+7:8i) is byte (offset+i) of the entry when i < size, and 0 otherwise.
- R6: An invalidating snoop (read-exclusive 1, invalidate 2, write-invalidate 3) that selects a writeback entry sets only that entry's bit in `wb_mark_o` in the accept cycle. Commands 2 and 3 produce no response in this case.
- R7: If neither the miss entry nor the writeback buffer applies, `coh_req_o` pulses in the accept cycle. If `coh_supply_i` is 1 in that cycle, a response follows with satisfied=1, shared=0, NACK=0 and bytes taken from `coh_data_i` by the rule of R5. Otherwise no response follows.
- R8: `rsp_valid_o` is high for one cycle exactly HIT_LAT cycles after the accept cycle. When it is low, all response flags and data are 0.
- R9: `busy_o` is 1 on each cycle strictly between an accept that needs a response and that response. It is 0 in the response cycle itself, so a new snoop can be accepted there.
- R10: `rsp_err_o` accompanies a data response when offset+size exceeds BLK_BYTES. Requested bytes that lie past the block end are returned as 0.
- R11: After reset, `busy_o`, `rsp_valid_o` and all pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snp_valid_i | input | 1 | Snoop offered |
| snp_cmd_i | input | 2 | 0 read, 1 read-exclusive, 2 invalidate, 3 write-invalidate |
| snp_addr_i | input | ADDR_W | Snoop byte address |
| snp_size_i | input | log2(BLK_BYTES)+1 | Requested byte count, 0..BLK_BYTES |
| busy_o | output | 1 | Response pending, snoop not accepted |
| miss_hit_i | input | 1 | Miss entry for this block exists |
| miss_active_i | input | 1 | That miss entry is in service |
| miss_inval_i | input | 1 | Its pending request is an invalidate type |
| miss_fill_i | input | 1 | Its pending request is a cache fill |
| miss_append_inv_o | output | 1 | Append an invalidate target to the miss entry |
| wb_valid_i | input | WB_DEPTH | Writeback entry valid |
| wb_uncache_i | input | WB_DEPTH | Writeback entry uncacheable |
| wb_addr_i | input | WB_DEPTH*ADDR_W | Writeback entry addresses, entry k at bits k*ADDR_W |
| wb_data_i | input | WB_DEPTH*BLK_BYTES*8 | Writeback entry block data |
| wb_mark_o | output | WB_DEPTH | Mark that writeback entry in service |
| coh_req_o | output | 1 | Hand the snoop to the coherence policy |
| coh_supply_i | input | 1 | Policy will supply data |
| coh_data_i | input | BLK_BYTES*8 | Cached block data from the policy side |
| rsp_valid_o | output | 1 | Snoop response |
| rsp_sat_o | output | 1 | Snoop satisfied |
| rsp_nack_o | output | 1 | Snoop refused, retry |
| rsp_shared_o | output | 1 | Line stays shared |
| rsp_err_o | output | 1 | Requested range overruns the block |
| rsp_data_o | output | BLK_BYTES*8 | Requested bytes, byte 0 in bits 7:0 |

## Verification
Two things can land in the same cycle. One is the response of an earlier snoop, which is due when busy drops. The other is the acceptance of a new snoop, with its append, mark or policy pulse. A read-exclusive that hits a writeback entry adds a second overlap: it raises a mark pulse and queues a data response in one cycle. The bench provokes these by offering snoops back to back, in a directed run and in a long random run, over a four-block address space where writeback, miss and policy cases collide often. A behavioural model, which tracks the pending response by due cycle, predicts every output, and all of them are compared on every clock.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    SNP_RD    = 2'd0,
    SNP_RDX   = 2'd1,
    SNP_INV   = 2'd2,
    SNP_WRINV = 2'd3
  } snp_cmd_e;

  function automatic logic cmd_reads(input logic [1:0] cmd);
    return (cmd == SNP_RD) || (cmd == SNP_RDX);
  endfunction

  function automatic logic cmd_invals(input logic [1:0] cmd);
    return cmd != SNP_RD;
  endfunction
endpackage

// File: rtl/snp_wb_select.sv
module snp_wb_select #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned DEPTH  = 4
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DEPTH-1:0]        valid_i,
  input  logic [DEPTH-1:0]        uncache_i,
  input  logic [DEPTH*ADDR_W-1:0] wb_addr_i,
  output logic                    hit_o,
  output logic [DEPTH-1:0]        sel_oh_o
);
  localparam int unsigned TAG_W = ADDR_W - OFF_W;

  logic [DEPTH-1:0] cand;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign cand[k] = valid_i[k] & ~uncache_i[k] &
                     (wb_addr_i[k*ADDR_W+OFF_W +: TAG_W] == addr_i[ADDR_W-1:OFF_W]);
  end

  // isolate lowest set bit: lowest index wins
  assign sel_oh_o = cand & (~cand + DEPTH'(1));
  assign hit_o    = |cand;
endmodule

// File: rtl/snp_byte_extract.sv
module snp_byte_extract #(
  parameter  int unsigned BLK_BYTES = 16,
  localparam int unsigned OFF_W     = $clog2(BLK_BYTES),
  localparam int unsigned BLK_W     = BLK_BYTES * 8
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W:0]   size_i,
  output logic [BLK_W-1:0] data_o,
  output logic             err_o
);
  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_byte
    logic [OFF_W:0] src;
    logic           keep;
    assign src  = {1'b0, off_i} + (OFF_W+1)'(i);
    assign keep = ((OFF_W+1)'(i) < size_i) && !src[OFF_W];
    assign data_o[i*8 +: 8] = keep ? blk_i[src[OFF_W-1:0]*8 +: 8] : 8'h00;
  end

  assign err_o = ({2'b00, off_i} + {1'b0, size_i}) > (OFF_W+2)'(BLK_BYTES);
endmodule

// File: rtl/snp_rsp_pipe.sv
module snp_rsp_pipe #(
  parameter int unsigned HIT_LAT = 3,
  parameter int unsigned BLK_W   = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             nack_i,
  input  logic             shared_i,
  input  logic             err_i,
  input  logic [BLK_W-1:0] data_i,
  output logic             busy_o,
  output logic             rsp_valid_o,
  output logic             rsp_sat_o,
  output logic             rsp_nack_o,
  output logic             rsp_shared_o,
  output logic             rsp_err_o,
  output logic [BLK_W-1:0] rsp_data_o
);
  localparam int unsigned CNT_W = $clog2(HIT_LAT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             nack_q, shared_q, err_q;
  logic [BLK_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      nack_q   <= 1'b0;
      shared_q <= 1'b0;
      err_q    <= 1'b0;
      data_q   <= '0;
    end else if (load_i) begin
      cnt_q    <= CNT_W'(HIT_LAT);
      nack_q   <= nack_i;
      shared_q <= shared_i;
      err_q    <= err_i;
      data_q   <= data_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign rsp_valid_o  = (cnt_q == CNT_W'(1));
  assign busy_o       = (cnt_q > CNT_W'(1));
  // every issued response is a satisfied one
  assign rsp_sat_o    = rsp_valid_o;
  assign rsp_nack_o   = rsp_valid_o & nack_q;
  assign rsp_shared_o = rsp_valid_o & shared_q;
  assign rsp_err_o    = rsp_valid_o & err_q;
  assign rsp_data_o   = rsp_valid_o ? data_q : '0;
endmodule

// File: rtl/snoop_resolver.sv
module snoop_resolver
  import snp_pkg::*;
#(
  parameter  int unsigned ADDR_W    = 32,
  parameter  int unsigned BLK_BYTES = 16,
  parameter  int unsigned WB_DEPTH  = 4,
  parameter  int unsigned HIT_LAT   = 3,
  localparam int unsigned OFF_W     = $clog2(BLK_BYTES),
  localparam int unsigned BLK_W     = BLK_BYTES * 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       snp_valid_i,
  input  logic [1:0]                 snp_cmd_i,
  input  logic [ADDR_W-1:0]          snp_addr_i,
  input  logic [OFF_W:0]             snp_size_i,
  output logic                       busy_o,
  input  logic                       miss_hit_i,
  input  logic                       miss_active_i,
  input  logic                       miss_inval_i,
  input  logic                       miss_fill_i,
  output logic                       miss_append_inv_o,
  input  logic [WB_DEPTH-1:0]        wb_valid_i,
  input  logic [WB_DEPTH-1:0]        wb_uncache_i,
  input  logic [WB_DEPTH*ADDR_W-1:0] wb_addr_i,
  input  logic [WB_DEPTH*BLK_W-1:0]  wb_data_i,
  output logic [WB_DEPTH-1:0]        wb_mark_o,
  output logic                       coh_req_o,
  input  logic                       coh_supply_i,
  input  logic [BLK_W-1:0]           coh_data_i,
  output logic                       rsp_valid_o,
  output logic                       rsp_sat_o,
  output logic                       rsp_nack_o,
  output logic                       rsp_shared_o,
  output logic                       rsp_err_o,
  output logic [BLK_W-1:0]           rsp_data_o
);
  logic                accept;
  logic                rd_cmd, inv_cmd;
  logic                miss_case, nack_case, wb_path, coh_path;
  logic                wb_hit;
  logic [WB_DEPTH-1:0] wb_sel;
  logic [BLK_W-1:0]    wb_blk, src_blk, ext_data;
  logic                ext_err;
  logic                load;

  assign accept  = snp_valid_i & ~busy_o;
  assign rd_cmd  = cmd_reads(snp_cmd_i);
  assign inv_cmd = cmd_invals(snp_cmd_i);

  // priority 1: conflicting in-flight miss
  assign miss_case = miss_hit_i & miss_active_i;
  assign nack_case = miss_case & (miss_inval_i | ~miss_fill_i) & rd_cmd;

  // priority 2: pending writeback able to supply
  snp_wb_select #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .DEPTH (WB_DEPTH)
  ) u_wb_sel (
    .addr_i   (snp_addr_i),
    .valid_i  (wb_valid_i),
    .uncache_i(wb_uncache_i),
    .wb_addr_i(wb_addr_i),
    .hit_o    (wb_hit),
    .sel_oh_o (wb_sel)
  );

  always_comb begin
    wb_blk = '0;
    for (int k = 0; k < WB_DEPTH; k++) begin
      if (wb_sel[k]) wb_blk = wb_blk | wb_data_i[k*BLK_W +: BLK_W];
    end
  end

  assign wb_path  = ~miss_case & wb_hit;
  // priority 3: coherence policy
  assign coh_path = ~miss_case & ~wb_hit;
  assign src_blk  = wb_path ? wb_blk : coh_data_i;

  snp_byte_extract #(
    .BLK_BYTES(BLK_BYTES)
  ) u_extract (
    .blk_i (src_blk),
    .off_i (snp_addr_i[OFF_W-1:0]),
    .size_i(snp_size_i),
    .data_o(ext_data),
    .err_o (ext_err)
  );

  assign miss_append_inv_o = accept & miss_case & ~nack_case;
  assign wb_mark_o         = (accept & wb_path & inv_cmd) ? wb_sel : '0;
  assign coh_req_o         = accept & coh_path;

  assign load = accept & (nack_case | (wb_path & rd_cmd) | (coh_path & coh_supply_i));

  snp_rsp_pipe #(
    .HIT_LAT(HIT_LAT),
    .BLK_W  (BLK_W)
  ) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .nack_i      (miss_case),
    .shared_i    (wb_path),
    .err_i       (~miss_case & ext_err),
    .data_i      (miss_case ? '0 : ext_data),
    .busy_o      (busy_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_sat_o   (rsp_sat_o),
    .rsp_nack_o  (rsp_nack_o),
    .rsp_shared_o(rsp_shared_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_data_o  (rsp_data_o)
  );
endmodule

// File: rtl/snoop_resolver_chk.sv
module snoop_resolver_chk #(
  parameter int unsigned WB_DEPTH = 4,
  parameter int unsigned BLK_W    = 128
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                busy_o,
  input logic                miss_append_inv_o,
  input logic [WB_DEPTH-1:0] wb_mark_o,
  input logic                coh_req_o,
  input logic                rsp_valid_o,
  input logic                rsp_sat_o,
  input logic                rsp_nack_o,
  input logic                rsp_shared_o,
  input logic                rsp_err_o,
  input logic [BLK_W-1:0]    rsp_data_o
);
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0({miss_append_inv_o, |wb_mark_o, coh_req_o})); // R3
  AST_APPEND_NO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni) miss_append_inv_o |=> !busy_o); // R3
  AST_MARK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(wb_mark_o)); // R6
  AST_NO_ACT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_o |-> (!miss_append_inv_o && wb_mark_o == '0 && !coh_req_o)); // R1
  AST_NACK_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni) rsp_nack_o |-> (rsp_sat_o && !rsp_shared_o && !rsp_err_o)); // R2
  AST_SHARED_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni) rsp_shared_o |-> (rsp_sat_o && !rsp_nack_o)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) !rsp_valid_o |-> (!rsp_sat_o && !rsp_nack_o && !rsp_shared_o && !rsp_err_o && rsp_data_o == '0)); // R8
  AST_BUSY_NO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_o |-> !rsp_valid_o); // R9
  AST_ERR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni) rsp_err_o |-> (rsp_sat_o && !rsp_nack_o)); // R10
endmodule

bind snoop_resolver snoop_resolver_chk #(
  .WB_DEPTH(WB_DEPTH),
  .BLK_W   (BLK_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .busy_o           (busy_o),
  .miss_append_inv_o(miss_append_inv_o),
  .wb_mark_o        (wb_mark_o),
  .coh_req_o        (coh_req_o),
  .rsp_valid_o      (rsp_valid_o),
  .rsp_sat_o        (rsp_sat_o),
  .rsp_nack_o       (rsp_nack_o),
  .rsp_shared_o     (rsp_shared_o),
  .rsp_err_o        (rsp_err_o),
  .rsp_data_o       (rsp_data_o)
);

// File: tb/snoop_resolver_tb.sv
module snoop_resolver_tb;
  localparam int ADDR_W    = 32;
  localparam int BLK_BYTES = 16;
  localparam int WB_DEPTH  = 4;
  localparam int HIT_LAT   = 3;
  localparam int OFF_W     = $clog2(BLK_BYTES);
  localparam int BLK_W     = BLK_BYTES * 8;

  logic                       clk_i = 1'b0;
  logic                       rst_ni = 1'b0;
  logic                       snp_valid_i = 1'b0;
  logic [1:0]                 snp_cmd_i = '0;
  logic [ADDR_W-1:0]          snp_addr_i = '0;
  logic [OFF_W:0]             snp_size_i = '0;
  logic                       busy_o;
  logic                       miss_hit_i = 1'b0, miss_active_i = 1'b0;
  logic                       miss_inval_i = 1'b0, miss_fill_i = 1'b0;
  logic                       miss_append_inv_o;
  logic [WB_DEPTH-1:0]        wb_valid_i = '0, wb_uncache_i = '0;
  logic [WB_DEPTH*ADDR_W-1:0] wb_addr_i = '0;
  logic [WB_DEPTH*BLK_W-1:0]  wb_data_i = '0;
  logic [WB_DEPTH-1:0]        wb_mark_o;
  logic                       coh_req_o;
  logic                       coh_supply_i = 1'b0;
  logic [BLK_W-1:0]           coh_data_i = '0;
  logic                       rsp_valid_o, rsp_sat_o, rsp_nack_o, rsp_shared_o, rsp_err_o;
  logic [BLK_W-1:0]           rsp_data_o;

  always #5 clk_i = ~clk_i;

  snoop_resolver #(
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .WB_DEPTH(WB_DEPTH), .HIT_LAT(HIT_LAT)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .snp_valid_i(snp_valid_i), .snp_cmd_i(snp_cmd_i),
    .snp_addr_i(snp_addr_i), .snp_size_i(snp_size_i), .busy_o(busy_o),
    .miss_hit_i(miss_hit_i), .miss_active_i(miss_active_i), .miss_inval_i(miss_inval_i),
    .miss_fill_i(miss_fill_i), .miss_append_inv_o(miss_append_inv_o),
    .wb_valid_i(wb_valid_i), .wb_uncache_i(wb_uncache_i), .wb_addr_i(wb_addr_i),
    .wb_data_i(wb_data_i), .wb_mark_o(wb_mark_o), .coh_req_o(coh_req_o),
    .coh_supply_i(coh_supply_i), .coh_data_i(coh_data_i), .rsp_valid_o(rsp_valid_o),
    .rsp_sat_o(rsp_sat_o), .rsp_nack_o(rsp_nack_o), .rsp_shared_o(rsp_shared_o),
    .rsp_err_o(rsp_err_o), .rsp_data_o(rsp_data_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // pending response as predicted by the model
  bit               p_v = 0;
  int               p_due = 0;
  logic             p_nack, p_sh, p_err;
  logic [BLK_W-1:0] p_data;
  string            p_tag = "R8", p_dtag = "R8";

  // expectation for the current cycle
  bit                e_app, e_coh, e_load;
  logic [WB_DEPTH-1:0] e_mark;
  logic              e_nack, e_sh, e_err;
  logic [BLK_W-1:0]  e_data;
  string             e_tag, e_dtag;

  task automatic check(string tag, string what, logic [BLK_W-1:0] act, logic [BLK_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [BLK_W-1:0] pick(logic [BLK_W-1:0] src, int off, int sz);
    logic [BLK_W-1:0] r = '0;
    for (int i = 0; i < BLK_BYTES; i++)
      if (i < sz && off + i < BLK_BYTES) r[i*8 +: 8] = src[(off+i)*8 +: 8];
    return r;
  endfunction

  task automatic model_eval();
    int off, sz, hit_k;
    bit rd, inv, bsy;
    e_app = 0; e_coh = 0; e_mark = '0; e_load = 0;
    e_nack = 0; e_sh = 0; e_err = 0; e_data = '0; e_tag = "R2"; e_dtag = "R2";
    bsy = p_v && (p_due > cyc);
    if (!snp_valid_i || bsy) return;
    rd  = (snp_cmd_i == 2'd0) || (snp_cmd_i == 2'd1);
    inv = (snp_cmd_i != 2'd0);
    off = int'(snp_addr_i[OFF_W-1:0]);
    sz  = int'(snp_size_i);
    if (miss_hit_i && miss_active_i) begin
      if ((miss_inval_i || !miss_fill_i) && rd) begin
        e_load = 1; e_nack = 1;                       // R2
      end else e_app = 1;                             // R3
    end else begin
      hit_k = -1;
      for (int k = 0; k < WB_DEPTH; k++)
        if (hit_k < 0 && wb_valid_i[k] && !wb_uncache_i[k] &&
            wb_addr_i[k*ADDR_W+OFF_W +: ADDR_W-OFF_W] == snp_addr_i[ADDR_W-1:OFF_W])
          hit_k = k;
      if (hit_k >= 0) begin                           // R4
        if (inv) e_mark[hit_k] = 1'b1;                // R6
        if (rd) begin                                 // R5
          e_load = 1; e_sh = 1; e_tag = "R4"; e_dtag = "R5";
          e_data = pick(wb_data_i[hit_k*BLK_W +: BLK_W], off, sz);
          e_err  = (off + sz > BLK_BYTES);
        end
      end else begin                                  // R7
        e_coh = 1;
        if (coh_supply_i) begin
          e_load = 1; e_tag = "R7"; e_dtag = "R7";
          e_data = pick(coh_data_i, off, sz);
          e_err  = (off + sz > BLK_BYTES);
        end
      end
    end
  endtask

  task automatic compare();
    bit bsy, rv;
    string pt;
    bsy = p_v && (p_due > cyc);
    rv  = p_v && (p_due == cyc);
    check("R9", "busy", BLK_W'(busy_o), BLK_W'(bsy));
    check("R8", "rsp_valid", BLK_W'(rsp_valid_o), BLK_W'(rv));
    if (rv) begin
      check(p_tag, "sat", BLK_W'(rsp_sat_o), BLK_W'(1));
      check(p_tag, "nack", BLK_W'(rsp_nack_o), BLK_W'(p_nack));
      check(p_tag, "shared", BLK_W'(rsp_shared_o), BLK_W'(p_sh));
      check(p_dtag, "data", rsp_data_o, p_data);
      check("R10", "err", BLK_W'(rsp_err_o), BLK_W'(p_err));
    end else begin
      check("R8", "idle flags", BLK_W'({rsp_sat_o, rsp_nack_o, rsp_shared_o, rsp_err_o}), '0);
      check("R8", "idle data", rsp_data_o, '0);
    end
    pt = (snp_valid_i && bsy) ? "R1" : "R3";
    check(pt, "append", BLK_W'(miss_append_inv_o), BLK_W'(e_app));
    pt = (snp_valid_i && bsy) ? "R1" : "R6";
    check(pt, "mark", BLK_W'(wb_mark_o), BLK_W'(e_mark));
    pt = (snp_valid_i && bsy) ? "R1" : "R7";
    check(pt, "coh_req", BLK_W'(coh_req_o), BLK_W'(e_coh));
  endtask

  task automatic model_update();
    if (p_v && p_due == cyc) p_v = 0;
    if (e_load) begin
      p_v = 1; p_due = cyc + HIT_LAT;
      p_nack = e_nack; p_sh = e_sh; p_err = e_err; p_data = e_data;
      p_tag = e_tag; p_dtag = e_dtag;
    end
    cyc++;
  endtask

  // inputs change at negedge; outputs compared 2 ns later
  task automatic step();
    #2;
    model_eval();
    compare();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
  endtask

  task automatic snoop(logic [1:0] c, int a, int sz);
    snp_valid_i = 1'b1;
    snp_cmd_i   = c;
    snp_addr_i  = ADDR_W'(a);
    snp_size_i  = (OFF_W+1)'(sz);
    step();
    snp_valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    snp_valid_i = 1'b0;
    repeat (n) step();
  endtask

  task automatic set_wb(int k, bit v, bit u, int a);
    wb_valid_i[k]   = v;
    wb_uncache_i[k] = u;
    wb_addr_i[k*ADDR_W +: ADDR_W] = ADDR_W'(a);
    for (int b = 0; b < BLK_BYTES; b++) wb_data_i[k*BLK_W + b*8 +: 8] = 8'((k << 5) + b + 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R11: reset state
    @(negedge clk_i);
    @(negedge clk_i);
    #2;
    check("R11", "busy in reset", BLK_W'(busy_o), '0);
    check("R11", "rsp_valid in reset", BLK_W'(rsp_valid_o), '0);
    check("R11", "pulses in reset", BLK_W'({miss_append_inv_o, wb_mark_o, coh_req_o}), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);

    // R2: in-service invalidate-type miss refuses a read
    miss_hit_i = 1; miss_active_i = 1; miss_inval_i = 1; miss_fill_i = 1;
    snoop(2'd0, 32'h24, 4);
    idle(HIT_LAT);
    miss_inval_i = 0; miss_fill_i = 0;                 // R2: non-fill miss
    snoop(2'd1, 32'h20, 8);
    idle(HIT_LAT);

    // R3: append cases
    miss_inval_i = 1; miss_fill_i = 1;
    snoop(2'd2, 32'h20, 0);
    snoop(2'd3, 32'h20, 16);
    miss_inval_i = 0;
    snoop(2'd0, 32'h28, 4);
    idle(2);

    // R4: writeback selection, uncacheable skipped, miss not in service
    miss_active_i = 0;
    set_wb(0, 1, 1, 32'h2c);
    set_wb(1, 1, 0, 32'h21);
    set_wb(2, 1, 0, 32'h20);
    set_wb(3, 1, 0, 32'h50);
    snoop(2'd0, 32'h24, 4);                            // R5
    idle(HIT_LAT);
    snoop(2'd1, 32'h28, 8);                            // R6 with response
    idle(HIT_LAT);
    snoop(2'd2, 32'h20, 0);                            // R6 mark only
    snoop(2'd3, 32'h53, 4);
    idle(1);
    snoop(2'd0, 32'h2c, 8);                            // R10 overrun
    idle(HIT_LAT);
    snoop(2'd0, 32'h20, 16);                           // R5 full block
    idle(HIT_LAT);

    // R7: coherence policy path
    miss_hit_i = 0;
    coh_data_i = {4{32'hdeadbeef}} ^ {16{8'h11}};
    coh_supply_i = 1;
    snoop(2'd0, 32'h73, 16);                           // R10 overrun via policy
    idle(HIT_LAT);
    coh_supply_i = 0;
    snoop(2'd0, 32'h70, 4);
    snoop(2'd2, 32'h70, 0);
    idle(1);

    // R1 R9: back-to-back snoops, response and new accept share a cycle
    coh_supply_i = 1;
    for (int n = 0; n < 8; n++) begin
      snp_valid_i = 1'b1;
      snp_cmd_i   = 2'(n);
      snp_addr_i  = ADDR_W'(32'h20 + 32'h28 * (n % 3));
      snp_size_i  = (OFF_W+1)'(n + 2);
      step();
    end
    idle(HIT_LAT + 1);

    // random mix over four blocks
    for (int n = 0; n < 4000; n++) begin
      snp_valid_i   = ($urandom_range(0, 9) < 6);
      snp_cmd_i     = 2'($urandom_range(0, 3));
      snp_addr_i    = ADDR_W'($urandom_range(0, 63));
      snp_size_i    = (OFF_W+1)'($urandom_range(0, BLK_BYTES));
      miss_hit_i    = ($urandom_range(0, 3) == 0);
      miss_active_i = ($urandom_range(0, 1) == 0);
      miss_inval_i  = ($urandom_range(0, 1) == 0);
      miss_fill_i   = ($urandom_range(0, 1) == 0);
      coh_supply_i  = ($urandom_range(0, 1) == 0);
      coh_data_i    = {$urandom(), $urandom(), $urandom(), $urandom()};
      if ($urandom_range(0, 7) == 0) begin
        for (int k = 0; k < WB_DEPTH; k++) begin
          set_wb(k, $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
                 int'($urandom_range(0, 63)));
          wb_data_i[k*BLK_W +: BLK_W] = {$urandom(), $urandom(), $urandom(), $urandom()};
        end
      end
      step();
    end
    idle(HIT_LAT + 1);
    finish_run();
  end
endmodule